// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

This block is a register-mapped watchdog. A down-counter is loaded from a programmable reload value. It decrements on every clock where counting is enabled and the external tick-enable input is high. Software keeps the system alive by writing one fixed 16-bit key to the restart register. That write copies the reload value into the counter, and a write of any other value does nothing. When the counter is at zero and takes one more step, the block records an expiry, reloads itself and can issue a one-cycle system reset request.

A programmable early-warning threshold sits in the upper control bits. When this warning is enabled, the block raises a sticky interrupt status once the running count is at or below that threshold. The interrupt output follows that status bit. A write-one clear register removes all recorded events. The tick source and the logic that distributes the reset request lie outside the block.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the count equals the RELOAD_INIT parameter, the reload register also holds RELOAD_INIT, control and status read as 0, and resetReq, irq and resetScope are 0.
- R2: Bus word offsets are decoded from addr[4:2]. The reload register at byte offset 0x04 and the control register at 0x0C read back what was written. Control bits 6:5 appear on resetScope.
- R3: A write of exactly 0x00004755 to offset 0x08 makes the count equal to the reload value on the next cycle. It takes priority over a tick in that cycle. A write of any other value to 0x08 leaves the count unchanged.
- R4: With control bit 0 set, the count drops by one on each clock where tick is high. It holds on clocks where tick is low.
- R5: With control bit 0 clear, the count is frozen whatever tick does.
- R6: A tick step taken at count 0 reloads the counter and sets status bit 0 (offset 0x10). In the following cycle resetReq is high for exactly one cycle if control bit 1 is set. resetReq stays low if control bit 1 is clear.
- R7: Control bits 31:10 form an unsigned threshold. While control bits 0 and 2 are both set and the count is at or below that threshold, status bit 2 is set on the next edge and stays set. irq equals status bit 2. With control bit 2 clear, the bit is never set.
- R8: A write to offset 0x14 with bit 0 set clears every status bit on the next cycle, and a clear wins over a simultaneous set. A write with bit 0 clear has no effect.
- R9: Offset 0x00 reads the current count and ignores writes. Offset 0x08 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Combinational read data for addr |
| tick | input | 1 | Count-enable pulse from the time base |
| resetReq | output | 1 | One-cycle reset request after an expiry |
| irq | output | 1 | Early-warning interrupt level |
| resetScope | output | 2 | Reset scope field selected in control |
| count | output | 32 | Current counter value |

## Verification
The bench builds the block with DATA_W of 32 and RELOAD_INIT set to 0xFFFF. Because it reloads small values through the restart key and drives tick directly, expiry, the reset pulse and the threshold crossing all fall within a few tens of cycles. A threshold of 5 against a reload of 20 places the warning crossing at a known tick. It is then checked together with the clear-register priority and the key-rejection path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [15:0] RESTART_KEY = 16'h4755;
  localparam int THR_LSB = 10;

  localparam logic [2:0] OFS_COUNT  = 3'd0;
  localparam logic [2:0] OFS_RELOAD = 3'd1;
  localparam logic [2:0] OFS_KICK   = 3'd2;
  localparam logic [2:0] OFS_CTRL   = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_CLEAR  = 3'd5;

  localparam int BIT_RUN    = 0;
  localparam int BIT_RSTEN  = 1;
  localparam int BIT_WARNEN = 2;
  localparam int ST_EXPIRED = 0;
  localparam int ST_WARN    = 2;

  typedef struct packed {
    logic load;
    logic step;
  } wdog_strobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdog_strobe_t      strobe,
  input  logic [DATA_W-1:0] reloadVal,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  assign expire = strobe.step && !strobe.load && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= RELOAD_INIT;
    end else if (strobe.load || expire) begin
      count <= reloadVal;
    end else if (strobe.step) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              tick,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output wdog_strobe_t      strobe,
  output logic [DATA_W-1:0] reloadVal,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] rdata,
  output logic              resetReq
);
  localparam int THR_W = DATA_W - THR_LSB;

  logic [2:0]        wordSel;
  logic              keyHit;
  logic              clearHit;
  logic              warnSet;
  logic [DATA_W-1:0] threshold;

  assign wordSel   = addr[4:2];
  assign keyHit    = we && (wordSel == OFS_KICK) && (wdata == DATA_W'(RESTART_KEY));
  assign clearHit  = we && (wordSel == OFS_CLEAR) && wdata[0];
  assign threshold = {{THR_LSB{1'b0}}, ctrlReg[DATA_W-1 -: THR_W]};
  assign warnSet   = ctrlReg[BIT_RUN] && ctrlReg[BIT_WARNEN] && (count <= threshold);

  assign strobe.load = keyHit;
  assign strobe.step = ctrlReg[BIT_RUN] && tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= RELOAD_INIT;
      ctrlReg   <= '0;
      statusReg <= '0;
      resetReq  <= 1'b0;
    end else begin
      resetReq <= expire && ctrlReg[BIT_RSTEN];
      if (we && wordSel == OFS_RELOAD) reloadVal <= wdata;
      if (we && wordSel == OFS_CTRL)   ctrlReg   <= wdata;
      if (clearHit) begin
        statusReg <= '0;
      end else begin
        if (expire)  statusReg[ST_EXPIRED] <= 1'b1;
        if (warnSet) statusReg[ST_WARN]    <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (wordSel)
      OFS_COUNT:  rdata = count;
      OFS_RELOAD: rdata = reloadVal;
      OFS_CTRL:   rdata = ctrlReg;
      OFS_STATUS: rdata = statusReg;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick,
  output logic              resetReq,
  output logic              irq,
  output logic [1:0]        resetScope,
  output logic [DATA_W-1:0] count
);
  wdog_strobe_t      strobe;
  logic              expire;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] statusReg;

  wdog_ctrl #(.DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .we(we), .tick(tick),
    .count(count), .expire(expire), .strobe(strobe), .reloadVal(reloadVal),
    .ctrlReg(ctrlReg), .statusReg(statusReg), .rdata(rdata), .resetReq(resetReq)
  );

  wdog_datapath #(.DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .count(count), .expire(expire)
  );

  assign irq        = statusReg[ST_WARN];
  assign resetScope = ctrlReg[6:5];
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              we,
  input logic              tick,
  input logic [DATA_W-1:0] count,
  input logic              resetReq,
  input logic              irq,
  input logic [DATA_W-1:0] ctrlReg,
  input logic [DATA_W-1:0] reloadVal
);
  logic keyHit;
  logic clrHit;
  assign keyHit = we && (addr[4:2] == OFS_KICK) && (wdata == DATA_W'(RESTART_KEY));
  assign clrHit = we && (addr[4:2] == OFS_CLEAR) && wdata[0];

  p_key_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    keyHit |=> count == $past(reloadVal));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[0] && tick && !keyHit && count != '0) |=> count == $past(count) - 1'b1);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[0] && !keyHit) |=> $stable(count));

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_pulse_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(ctrlReg[1]));

  p_warn_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(ctrlReg[2] && ctrlReg[0]));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> !irq);
endmodule

bind keyed_watchdog wdog_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .we(we), .tick(tick),
  .count(count), .resetReq(resetReq), .irq(irq), .ctrlReg(ctrlReg),
  .reloadVal(reloadVal)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  localparam logic [31:0] INIT = 32'h0000_FFFF;
  localparam int NVEC = 13;
  // entry: {isWrite, reqNum[3:0], addr[4:0], data[31:0]}; for reads data is the expected value
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 4'd2, 5'h04, 32'h0000_0020},
    {1'b0, 4'd2, 5'h04, 32'h0000_0020},
    {1'b1, 4'd3, 5'h08, 32'h0000_1234},
    {1'b0, 4'd3, 5'h00, INIT},
    {1'b1, 4'd3, 5'h08, 32'h0000_4755},
    {1'b0, 4'd3, 5'h00, 32'h0000_0020},
    {1'b1, 4'd9, 5'h00, 32'h0000_0005},
    {1'b0, 4'd9, 5'h00, 32'h0000_0020},
    {1'b0, 4'd9, 5'h08, 32'h0000_0000},
    {1'b1, 4'd2, 5'h0C, 32'h0000_1C60},
    {1'b0, 4'd2, 5'h0C, 32'h0000_1C60},
    {1'b1, 4'd2, 5'h0C, 32'h0000_0000},
    {1'b0, 4'd8, 5'h10, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] rdata;
  logic        resetReq;
  logic        irq;
  logic [1:0]  resetScope;
  logic [31:0] count;
  int nRun = 0;
  int nFail = 0;
  bit done = 0;
  bit sawPulse;

  always #4 clk = ~clk;

  keyed_watchdog #(.DATA_W(32), .RELOAD_INIT(INIT)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .tick(tick), .resetReq(resetReq), .irq(irq), .resetScope(resetScope), .count(count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, INIT);
    check("R1 resetReq", {31'b0, resetReq}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 scope", {30'b0, resetScope}, 0);
    readCheck("R1 reload", 5'h04, INIT);
    readCheck("R1 ctrl", 5'h0C, 0);
    readCheck("R1 status", 5'h10, 0);

    // table walk: R2 R3 R8 R9 register behaviour with tick idle
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      addr = VEC[i][36:32];
      wdata = VEC[i][31:0];
      we = VEC[i][41];
      #1;
      if (!VEC[i][41]) check($sformatf("R%0d table entry %0d", VEC[i][40:37], i), rdata, VEC[i][31:0]);
    end
    @(negedge clk); we = 1'b0;

    // R2 reset scope output
    busWrite(5'h0C, 32'h0000_0040);
    check("R2 scope", {30'b0, resetScope}, 32'd2);

    // R4 counting with tick, holding without
    busWrite(5'h04, 32'd10);
    busWrite(5'h08, 32'h0000_4755);
    busWrite(5'h0C, 32'h0000_0001);
    ticks(3);
    check("R4 after 3 ticks", count, 32'd7);
    repeat (2) @(negedge clk);
    check("R4 tick low holds", count, 32'd7);

    // R5 freeze when disabled
    busWrite(5'h0C, 32'h0000_0000);
    ticks(3);
    check("R5 frozen", count, 32'd7);

    // R6 expiry with reset request
    busWrite(5'h04, 32'd2);
    busWrite(5'h08, 32'h0000_4755);
    busWrite(5'h0C, 32'h0000_0003);
    @(negedge clk);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 pulse high", {31'b0, resetReq}, 1);
    check("R6 reloaded", count, 32'd2);
    @(negedge clk);
    tick = 1'b0;
    check("R6 pulse one cycle", {31'b0, resetReq}, 0);
    check("R6 count after", count, 32'd1);
    readCheck("R6 status expired", 5'h10, 32'h1);

    // R8 clear register
    busWrite(5'h14, 32'h0);
    readCheck("R8 no-op clear", 5'h10, 32'h1);
    busWrite(5'h14, 32'h1);
    readCheck("R8 cleared", 5'h10, 32'h0);

    // R6 expiry without reset request
    busWrite(5'h04, 32'd1);
    busWrite(5'h08, 32'h0000_4755);
    busWrite(5'h0C, 32'h0000_0001);
    sawPulse = 0;
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (resetReq) sawPulse = 1;
    end
    tick = 1'b0;
    check("R6 no pulse when disabled", {31'b0, sawPulse}, 0);
    readCheck("R6 status set anyway", 5'h10, 32'h1);
    busWrite(5'h14, 32'h1);

    // R7 early warning at threshold 5
    busWrite(5'h04, 32'd20);
    busWrite(5'h08, 32'h0000_4755);
    busWrite(5'h0C, (32'd5 << 10) | 32'h5);
    ticks(14);
    @(negedge clk);
    check("R7 above threshold", {31'b0, irq}, 0);
    ticks(1);
    check("R7 count at threshold", count, 32'd5);
    @(negedge clk);
    check("R7 irq raised", {31'b0, irq}, 1);
    readCheck("R7 status warn", 5'h10, 32'h4);

    // R7 disabled warning stays clear; R8 clear drops irq
    busWrite(5'h0C, (32'd5 << 10) | 32'h1);
    busWrite(5'h14, 32'h1);
    repeat (2) @(negedge clk);
    check("R7 no warn when disabled", {31'b0, irq}, 0);

    // R3 key restart mid-count
    busWrite(5'h08, 32'h0000_4755);
    check("R3 restart reload", count, 32'd20);

    finishRun();
  end
endmodule